// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside one processor core and makes load-exclusive / store-exclusive pairs safe for atomic read-modify-write sequences. When the core issues a load-exclusive, the monitor remembers the word address it read. A later store-exclusive may update memory only if that reservation is still in place for the same word. The store-exclusive receives a status value for its destination register: zero when the write went ahead, nonzero when it was refused. Software retries the sequence on a nonzero status.

The monitor watches writes by other agents through a snoop port. A snooped write to the reserved word cancels the reservation. A context-switch pulse also cancels it. Only one reservation is held at a time. Every store-exclusive consumes the reservation, whether it passes or fails. The store gate and the status are combinational on the cycle of the store-exclusive request. The reservation itself is registered.

Top module: `excl_monitor`

## Requirements
- R1: A load-exclusive (`lx_req` high) records a reservation on the word of `lx_addr`. A store-exclusive to that word on a later cycle then passes, provided nothing has cleared the reservation in between.
- R2: Only one reservation is held. A new load-exclusive replaces the earlier one, so a store-exclusive to the old word then fails.
- R3: A store-exclusive fails when no reservation is held, or when the reservation is for a different word.
- R4: A snooped external write (`snp_vld` high) to the reserved word clears the reservation, so a later store-exclusive to that word fails. A snooped write to any other word leaves the reservation intact.
- R5: A context-switch pulse (`ctx_clr` high) clears the reservation. It fails a store-exclusive in the same cycle. It also wins over a load-exclusive in the same cycle, so no reservation is left afterwards.
- R6: On a store-exclusive, `sx_wen` is 1 and `sx_status` is 0 on a pass. On a fail, `sx_wen` is 0 and `sx_status` is 1. When there is no store-exclusive, both outputs are 0.
- R7: Every store-exclusive clears the reservation, whether it passes or fails. The exception is a load-exclusive in the same cycle: that load then sets the new reservation.
- R8: Addresses are compared by word. Address bits [1:0] are ignored in all comparisons.
- R9: A snooped write to the reserved word in the same cycle as a store-exclusive to that word makes the store-exclusive fail. A snooped write in the same cycle as a load-exclusive does not cancel the new reservation.
- R10: After reset, no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lx_req | input | 1 | Load-exclusive issued this cycle |
| lx_addr | input | ADDR_W | Byte address of the load-exclusive |
| sx_req | input | 1 | Store-exclusive issued this cycle |
| sx_addr | input | ADDR_W | Byte address of the store-exclusive |
| snp_vld | input | 1 | Write by another agent observed this cycle |
| snp_addr | input | ADDR_W | Byte address of the observed write |
| ctx_clr | input | 1 | Context-switch clear pulse |
| sx_wen | output | 1 | Store gate: memory write permitted |
| sx_status | output | STAT_W | Status for the store-exclusive destination register |

## Verification
The bound checker checks several rules on every cycle:
- a write is never permitted without a store-exclusive;
- a failing status never comes with a write;
- a context clear or a same-cycle conflicting snoop blocks the write;
- a cycle that consumes the reservation, or a context clear, leaves nothing for the next store-exclusive.

Other behaviours depend on history across many cycles: which word is reserved, replacement by a newer load, survival past snoops to other words, and the word-granular match. The bench shows these by running directed sequences and a long random stream over a small address pool, checked against its own reservation model.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W   = 32,
  parameter int STAT_W   = 32,
  parameter int WORD_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lx_req,
  input  logic [ADDR_W-1:0] lx_addr,
  input  logic              sx_req,
  input  logic [ADDR_W-1:0] sx_addr,
  input  logic              snp_vld,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              ctx_clr,
  output logic              sx_wen,
  output logic [STAT_W-1:0] sx_status
);
  localparam int TAG_W = ADDR_W - WORD_LSB;

  logic             held;
  logic [TAG_W-1:0] tag;

  wire [TAG_W-1:0] lx_tag  = lx_addr[ADDR_W-1:WORD_LSB];
  wire [TAG_W-1:0] sx_tag  = sx_addr[ADDR_W-1:WORD_LSB];
  wire [TAG_W-1:0] snp_tag = snp_addr[ADDR_W-1:WORD_LSB];

  wire snp_hit = snp_vld && held && (snp_tag == tag);
  wire pass    = held && (sx_tag == tag) && !snp_hit && !ctx_clr;

  assign sx_wen    = sx_req && pass;
  assign sx_status = (sx_req && !pass) ? STAT_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      tag  <= '0;
    end else if (ctx_clr) begin
      held <= 1'b0;
    end else if (lx_req) begin
      held <= 1'b1;
      tag  <= lx_tag;
    end else if (sx_req || snp_hit) begin
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ADDR_W   = 32,
  parameter int STAT_W   = 32,
  parameter int WORD_LSB = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lx_req,
  input logic [ADDR_W-1:0] sx_addr,
  input logic              sx_req,
  input logic              snp_vld,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              ctx_clr,
  input logic              sx_wen,
  input logic [STAT_W-1:0] sx_status
);
  AST_WEN_NEEDS_STX: assert property (@(posedge clk) disable iff (!rst_n)
    sx_wen |-> sx_req); // R6
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sx_status != '0) |-> !sx_wen); // R6
  AST_STATUS_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    sx_req |-> $onehot({sx_wen, sx_status != '0})); // R6
  AST_CTX_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_clr && sx_req) |-> !sx_wen); // R5
  AST_CTX_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clr |=> !sx_wen); // R5
  AST_STX_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (sx_req && !lx_req) |=> !sx_wen); // R7
  AST_SNOOP_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sx_req && snp_vld && snp_addr[ADDR_W-1:WORD_LSB] == sx_addr[ADDR_W-1:WORD_LSB]) |-> !sx_wen); // R9
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sx_wen); // R10
endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W), .WORD_LSB(WORD_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .lx_req(lx_req), .sx_addr(sx_addr), .sx_req(sx_req),
  .snp_vld(snp_vld), .snp_addr(snp_addr), .ctx_clr(ctx_clr),
  .sx_wen(sx_wen), .sx_status(sx_status));

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lx_req = 0, sx_req = 0, snp_vld = 0, ctx_clr = 0;
  logic [AW-1:0] lx_addr = '0, sx_addr = '0, snp_addr = '0;
  logic sx_wen;
  logic [SW-1:0] sx_status;

  int checks = 0;
  int errors = 0;
  logic          m_held = 1'b0;
  logic [AW-1:0] m_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .STAT_W(SW), .WORD_LSB(2)) uut (
    .clk(clk), .rst_n(rst_n), .lx_req(lx_req), .lx_addr(lx_addr),
    .sx_req(sx_req), .sx_addr(sx_addr), .snp_vld(snp_vld), .snp_addr(snp_addr),
    .ctx_clr(ctx_clr), .sx_wen(sx_wen), .sx_status(sx_status));

  function automatic logic same_word(logic [AW-1:0] a, logic [AW-1:0] b);
    return a[AW-1:2] == b[AW-1:2];
  endfunction

  function automatic logic exp_pass();
    return m_held && same_word(sx_addr, m_addr) && !ctx_clr &&
           !(snp_vld && same_word(snp_addr, m_addr));
  endfunction

  task automatic step(input logic l, input logic [AW-1:0] la,
                      input logic s, input logic [AW-1:0] sa,
                      input logic p, input logic [AW-1:0] pa,
                      input logic c, input string req);
    logic ew;
    logic [SW-1:0] es;
    @(negedge clk);
    lx_req = l; lx_addr = la; sx_req = s; sx_addr = sa;
    snp_vld = p; snp_addr = pa; ctx_clr = c;
    #1;
    ew = s && exp_pass();
    es = (s && !exp_pass()) ? SW'(1) : '0;
    checks++;
    if (sx_wen !== ew || sx_status !== es) begin
      errors++;
      $display("FAIL %s: wen=%0b status=%0d expected wen=%0b status=%0d", req, sx_wen, sx_status, ew, es);
    end
    if (c) m_held = 1'b0;
    else if (l) begin m_held = 1'b1; m_addr = la; end
    else if (s || (p && m_held && same_word(pa, m_addr))) m_held = 1'b0;
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, '0, 0, "idle");
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1000;
  localparam logic [AW-1:0] B = 32'h0000_2000;

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10: nothing held after reset
    step(0, '0, 1, '0, 0, '0, 0, "R10 stx after reset");
    step(0, '0, 1, A, 0, '0, 0, "R3 no reservation");
    // R1 basic pass, R6 status 0
    step(1, A, 0, '0, 0, '0, 0, "R1 ldx");
    idle();
    step(0, '0, 1, A, 0, '0, 0, "R1 R6 stx pass");
    // R7 second stx fails
    step(0, '0, 1, A, 0, '0, 0, "R7 consumed");
    // R3 wrong word
    step(1, A, 0, '0, 0, '0, 0, "R3 ldx");
    step(0, '0, 1, B, 0, '0, 0, "R3 mismatch fail");
    step(0, '0, 1, A, 0, '0, 0, "R7 failed stx consumed");
    // R8 low bits ignored
    step(1, A | 32'h1, 0, '0, 0, '0, 0, "R8 ldx");
    step(0, '0, 1, A | 32'h3, 0, '0, 0, "R8 pass with low bits");
    // R2 replace
    step(1, A, 0, '0, 0, '0, 0, "R2 ldx A");
    step(1, B, 0, '0, 0, '0, 0, "R2 ldx B");
    step(0, '0, 1, A, 0, '0, 0, "R2 old word fails");
    // R4 snoop
    step(1, A, 0, '0, 0, '0, 0, "R4 ldx");
    step(0, '0, 0, '0, 1, B, 0, "R4 snoop other");
    step(0, '0, 0, '0, 1, A | 32'h2, 0, "R4 snoop hit");
    step(0, '0, 1, A, 0, '0, 0, "R4 fail after snoop");
    step(1, A, 0, '0, 0, '0, 0, "R4 ldx2");
    step(0, '0, 0, '0, 1, B, 0, "R4 snoop other2");
    step(0, '0, 1, A, 0, '0, 0, "R4 survives other snoop");
    // R5 context clear
    step(1, A, 0, '0, 0, '0, 0, "R5 ldx");
    step(0, '0, 0, '0, 0, '0, 1, "R5 ctx");
    step(0, '0, 1, A, 0, '0, 0, "R5 fail after ctx");
    step(1, A, 0, '0, 0, '0, 0, "R5 ldx2");
    step(0, '0, 1, A, 0, '0, 1, "R5 ctx same cycle");
    step(1, A, 0, '0, 0, '0, 1, "R5 ctx beats ldx");
    step(0, '0, 1, A, 0, '0, 0, "R5 nothing after ctx+ldx");
    // R9 same-cycle snoop
    step(1, A, 0, '0, 0, '0, 0, "R9 ldx");
    step(0, '0, 1, A, 1, A, 0, "R9 snoop with stx fails");
    step(1, B, 0, '0, 1, B, 0, "R9 snoop with ldx");
    step(0, '0, 1, B, 0, '0, 0, "R9 ldx kept");
    // R7 stx with ldx same cycle
    step(1, A, 0, '0, 0, '0, 0, "R7 ldx");
    step(1, B, 1, A, 0, '0, 0, "R7 stx+ldx");
    step(0, '0, 1, B, 0, '0, 0, "R7 new reservation kept");
    // random
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a1, a2, a3;
      a1 = {28'h0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      a2 = {28'h0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      a3 = {28'h0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      step($urandom_range(0, 2) == 0, a1, $urandom_range(0, 2) == 0, a2,
           $urandom_range(0, 3) == 0, a3, $urandom_range(0, 15) == 0,
           "R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: expected completion before timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule